// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the privileged status state of a 32-bit processor core and performs the atomic steps of taking an exception and of returning from one. It keeps the current status register, plus a link register and a saved status register for each exception mode: fast interrupt, normal interrupt, supervisor, abort and undefined. User and system mode share one state and have no saved status, so nothing for them is held here. Fetch, decode, execute, memory and the rest of the register file stay outside. They reach the block through request lines, a return-address input and a program-counter redirect stream.

Several exception requests can arrive in one cycle. The block masks the two interrupt kinds with their disable bits and grants the highest-priority survivor. In the same cycle it banks the return address and the old status for the target mode, and it rewrites the status register: mode field, compact-state bit and interrupt masks. It then emits the handler vector on the redirect stream. A return request takes the link register of the current mode, subtracts the offset for the stated cause, and restores the saved status.

The redirect output is a valid/ready stream. Once `redir_valid` rises, `redir_pc` is held until a cycle in which `redir_ready` is high. That cycle completes the transfer, and `redir_valid` falls on the following edge. While the redirect is pending, the block accepts no entry and no return. A consumer that holds `redir_ready` low therefore stalls the whole sequencer.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the status register reads 0x000000D3: supervisor mode, both interrupt masks set, compact bit clear. `redir_valid` is 1 with `redir_pc` equal to `VEC_BASE`.
- R2: `exc_req` bit i names a cause: 0 reset, 1 data abort, 2 fast interrupt, 3 normal interrupt, 4 prefetch abort, 5 undefined, 6 software interrupt. A lower index has higher priority. `exc_ack` is one-hot on the granted cause in the cycle the entry is taken.
- R3: Bit 3 of `exc_req` is ignored while status bit 7 is set. Bit 2 is ignored while status bit 6 is set.
- R4: On entry, status bits [4:0] become the target mode: 10001 fast, 10010 normal interrupt, 10011 supervisor for reset and software interrupt, 10111 both aborts, 11011 undefined. Bit 5 clears and bit 7 sets. Bit 6 sets only for reset and fast interrupt and is otherwise kept. Bits 31:8 are kept.
- R5: On entry, `ret_addr` is written to the target mode's link register and the pre-entry status to its saved status register.
- R6: The entry redirect is `VEC_BASE` plus: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 normal interrupt, 0x1C fast interrupt.
- R7: A return in a banked mode loads the status register from that mode's saved status. It redirects to that mode's link register minus an offset chosen by `ret_cause` (same codes as R2): 4 for codes 2, 3 and 4, 8 for code 1, and 0 otherwise. `ret_ack` is high in that cycle. In user or system mode a return is ignored.
- R8: While `redir_valid` is high and `redir_ready` is low, `redir_pc` is held. No entry or return is accepted while `redir_valid` is high.
- R9: `tstate_wr` sets status bit 5 to `tstate_val` and changes no other bit.
- R10: `psr_wr` loads the whole status register in privileged modes. In user mode it changes only bits 31:28. `psr_wr` takes precedence over `tstate_wr`, and an entry or return takes precedence over both.
- R11: An entry and a return requested in the same accepted cycle resolve to the entry, with `ret_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 7 | Pending exception causes, bit index per R2 |
| ret_addr | input | 32 | Return address banked on entry |
| ret_req | input | 1 | Request to return from the current mode |
| ret_cause | input | 3 | Cause code selecting the return offset |
| tstate_wr | input | 1 | Write the compact-state bit |
| tstate_val | input | 1 | New compact-state value |
| psr_wr | input | 1 | Write the status register |
| psr_wdata | input | 32 | Status write data |
| exc_ack | output | 7 | One-hot granted cause |
| ret_ack | output | 1 | Return accepted this cycle |
| redir_valid | output | 1 | Redirect stream valid |
| redir_ready | input | 1 | Redirect stream ready |
| redir_pc | output | 32 | Redirect target address |
| psr_cur | output | 32 | Current status register |

## Verification
The bench builds the block with `DW` at 32 and `VEC_BASE` at 0xFFFF0000. Every vector therefore sits in a high region where an offset added in the wrong place, or a missing base, shows at once in the upper address bits. Link values are chosen so that subtracting 4 or 8 crosses a hex digit boundary, which exposes a wrong offset or a wrong cause code. The status words carry nonzero flag nibbles, so the bench can see bits 31:8 survive through entry, return and user-mode writes.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int unsigned NCAUSE = 7;
  localparam int unsigned CW     = $clog2(NCAUSE);
  localparam int unsigned NBANK  = 5;
  localparam int unsigned BW     = $clog2(NBANK);

  localparam int unsigned PSR_T = 5;
  localparam int unsigned PSR_F = 6;
  localparam int unsigned PSR_I = 7;

  typedef enum logic [CW-1:0] {
    CZ_RESET  = 3'd0,
    CZ_DABORT = 3'd1,
    CZ_FIQ    = 3'd2,
    CZ_IRQ    = 3'd3,
    CZ_PABORT = 3'd4,
    CZ_UNDEF  = 3'd5,
    CZ_SWI    = 3'd6
  } cause_e;

  typedef enum logic [4:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  typedef struct packed {
    logic          ok;
    logic [BW-1:0] idx;
  } bank_sel_t;

  function automatic mode_e cause_mode(cause_e c);
    case (c)
      CZ_FIQ:              return MD_FIQ;
      CZ_IRQ:              return MD_IRQ;
      CZ_DABORT, CZ_PABORT: return MD_ABT;
      CZ_UNDEF:            return MD_UND;
      default:             return MD_SVC;
    endcase
  endfunction

  function automatic logic [7:0] cause_vec(cause_e c);
    case (c)
      CZ_UNDEF:  return 8'h04;
      CZ_SWI:    return 8'h08;
      CZ_PABORT: return 8'h0C;
      CZ_DABORT: return 8'h10;
      CZ_IRQ:    return 8'h18;
      CZ_FIQ:    return 8'h1C;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] cause_ret_off(cause_e c);
    case (c)
      CZ_FIQ, CZ_IRQ, CZ_PABORT: return 4'd4;
      CZ_DABORT:                 return 4'd8;
      default:                   return 4'd0;
    endcase
  endfunction

  function automatic logic cause_masks_fast(cause_e c);
    return (c == CZ_RESET) || (c == CZ_FIQ);
  endfunction

  function automatic bank_sel_t mode_bank(logic [4:0] m);
    bank_sel_t s;
    s.ok  = 1'b1;
    s.idx = '0;
    case (m)
      MD_FIQ:  s.idx = BW'(0);
      MD_IRQ:  s.idx = BW'(1);
      MD_SVC:  s.idx = BW'(2);
      MD_ABT:  s.idx = BW'(3);
      MD_UND:  s.idx = BW'(4);
      default: s.ok  = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned N = NCAUSE,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic          irq_mask,
  input  logic          fiq_mask,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N-1:0] live;
  logic [N:0]   seen;

  always_comb begin
    live = req;
    live[int'(CZ_IRQ)] = req[int'(CZ_IRQ)] & ~irq_mask;
    live[int'(CZ_FIQ)] = req[int'(CZ_FIQ)] & ~fiq_mask;
  end

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant[i]  = live[i] & ~seen[i];
    assign seen[i+1] = seen[i] | live[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (live[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int unsigned NB = 5,
  parameter int unsigned DW = 32,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_link,
  input  logic [DW-1:0] wr_spsr,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_link,
  output logic [DW-1:0] rd_spsr
);

  logic [DW-1:0] link_q [NB];
  logic [DW-1:0] spsr_q [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < int'(NB); b++) begin
        link_q[b] <= '0;
        spsr_q[b] <= '0;
      end
    end else if (wr_en) begin
      for (int b = 0; b < int'(NB); b++) begin
        if (wr_idx == IW'(b)) begin
          link_q[b] <= wr_link;
          spsr_q[b] <= wr_spsr;
        end
      end
    end
  end

  always_comb begin
    rd_link = '0;
    rd_spsr = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (rd_idx == IW'(b)) begin
        rd_link = link_q[b];
        rd_spsr = spsr_q[b];
      end
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int unsigned    DW       = 32,
  parameter logic [DW-1:0]  VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] exc_req,
  input  logic [DW-1:0]     ret_addr,
  input  logic              ret_req,
  input  logic [CW-1:0]     ret_cause,
  input  logic              tstate_wr,
  input  logic              tstate_val,
  input  logic              psr_wr,
  input  logic [DW-1:0]     psr_wdata,
  output logic [NCAUSE-1:0] exc_ack,
  output logic              ret_ack,
  output logic              redir_valid,
  input  logic              redir_ready,
  output logic [DW-1:0]     redir_pc,
  output logic [DW-1:0]     psr_cur
);

  localparam logic [DW-1:0] PSR_RESET = DW'(8'hD3);

  logic [DW-1:0]     psr_q;
  logic              rv_q;
  logic [DW-1:0]     rpc_q;

  logic [NCAUSE-1:0] grant;
  logic              any_live;
  logic [CW-1:0]     win;
  cause_e            win_c;
  cause_e            ret_c;
  mode_e             tgt_mode;
  bank_sel_t         tgt_bank;
  bank_sel_t         cur_bank;
  logic              idle;
  logic              take;
  logic              ret_go;
  logic [DW-1:0]     rd_link;
  logic [DW-1:0]     rd_spsr;
  logic [DW-1:0]     psr_entry;
  logic [DW-1:0]     psr_write;
  logic [DW-1:0]     entry_pc;
  logic [DW-1:0]     return_pc;

  trap_arbiter #(.N(NCAUSE)) u_arb (
    .req      (exc_req),
    .irq_mask (psr_q[PSR_I]),
    .fiq_mask (psr_q[PSR_F]),
    .grant    (grant),
    .any      (any_live),
    .idx      (win)
  );

  assign win_c    = cause_e'(win);
  assign ret_c    = cause_e'(ret_cause);
  assign tgt_mode = cause_mode(win_c);
  assign tgt_bank = mode_bank(tgt_mode);
  assign cur_bank = mode_bank(psr_q[4:0]);

  assign idle   = ~rv_q;
  assign take   = idle & any_live;
  assign ret_go = idle & ~any_live & ret_req & cur_bank.ok;

  trap_bank #(.NB(NBANK), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take & tgt_bank.ok),
    .wr_idx  (tgt_bank.idx),
    .wr_link (ret_addr),
    .wr_spsr (psr_q),
    .rd_idx  (cur_bank.idx),
    .rd_link (rd_link),
    .rd_spsr (rd_spsr)
  );

  always_comb begin
    psr_entry        = psr_q;
    psr_entry[4:0]   = tgt_mode;
    psr_entry[PSR_T] = 1'b0;
    psr_entry[PSR_I] = 1'b1;
    if (cause_masks_fast(win_c)) psr_entry[PSR_F] = 1'b1;
  end

  always_comb begin
    if (psr_q[4:0] == MD_USR) psr_write = {psr_wdata[DW-1:DW-4], psr_q[DW-5:0]};
    else                      psr_write = psr_wdata;
  end

  assign entry_pc  = VEC_BASE + DW'(cause_vec(win_c));
  assign return_pc = rd_link - DW'(cause_ret_off(ret_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q <= PSR_RESET;
    end else if (take) begin
      psr_q <= psr_entry;
    end else if (ret_go) begin
      psr_q <= rd_spsr;
    end else if (psr_wr) begin
      psr_q <= psr_write;
    end else if (tstate_wr) begin
      psr_q[PSR_T] <= tstate_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b1;
      rpc_q <= VEC_BASE;
    end else if (take) begin
      rv_q  <= 1'b1;
      rpc_q <= entry_pc;
    end else if (ret_go) begin
      rv_q  <= 1'b1;
      rpc_q <= return_pc;
    end else if (rv_q && redir_ready) begin
      rv_q  <= 1'b0;
    end
  end

  assign exc_ack     = take ? grant : '0;
  assign ret_ack     = ret_go;
  assign redir_valid = rv_q;
  assign redir_pc    = rpc_q;
  assign psr_cur     = psr_q;

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
  import trap_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCAUSE-1:0] exc_ack,
  input logic              ret_ack,
  input logic              psr_wr,
  input logic              redir_valid,
  input logic              redir_ready,
  input logic [DW-1:0]     redir_pc,
  input logic [DW-1:0]     psr_cur
);

  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_ack));

  p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psr_cur[PSR_I] |-> !exc_ack[int'(CZ_IRQ)]);

  p_fiq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psr_cur[PSR_F] |-> !exc_ack[int'(CZ_FIQ)]);

  p_entry_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_ack) |=> (psr_cur[PSR_I] && !psr_cur[PSR_T]));

  p_entry_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_ack) |=> redir_valid);

  p_return_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ack |=> redir_valid);

  p_hold_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_ready) |=> (redir_valid && $stable(redir_pc)));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (exc_ack == '0 && !ret_ack));

  p_mode_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ack == '0 && !ret_ack && !psr_wr) |=> $stable(psr_cur[4:0]));

  p_entry_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_ack) |-> !ret_ack);

endmodule

bind trap_sequencer trap_sequencer_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_ack     (exc_ack),
  .ret_ack     (ret_ack),
  .psr_wr      (psr_wr),
  .redir_valid (redir_valid),
  .redir_ready (redir_ready),
  .redir_pc    (redir_pc),
  .psr_cur     (psr_cur)
);

// File: tb/trap_sequencer_bench.sv
module trap_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VB = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  exc_req;
  logic [31:0] ret_addr;
  logic        ret_req;
  logic [2:0]  ret_cause;
  logic        tstate_wr, tstate_val, psr_wr;
  logic [31:0] psr_wdata;
  logic [6:0]  exc_ack;
  logic        ret_ack, redir_valid, redir_ready;
  logic [31:0] redir_pc, psr_cur;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer #(.DW(32), .VEC_BASE(VB)) u_trap_sequencer (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_addr(ret_addr),
    .ret_req(ret_req), .ret_cause(ret_cause), .tstate_wr(tstate_wr),
    .tstate_val(tstate_val), .psr_wr(psr_wr), .psr_wdata(psr_wdata),
    .exc_ack(exc_ack), .ret_ack(ret_ack), .redir_valid(redir_valid),
    .redir_ready(redir_ready), .redir_pc(redir_pc), .psr_cur(psr_cur)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_pc(input logic [31:0] pc, input string tag);
    exp_q.push_back(pc);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops the scoreboard on each completed redirect transfer
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (rst_n && redir_valid && redir_ready) begin
      if (exp_q.size() == 0) begin
        check("R6/R7 unexpected redirect", redir_pc, 32'hDEAD_BEEF);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, redir_pc, e);
      end
    end
  end

  task automatic do_entry(input logic [6:0] req, input logic [31:0] ra, input logic with_ret,
                          input logic [6:0] exp_ack, input logic [31:0] exp_pc,
                          input logic [31:0] exp_psr, input string tag);
    exc_req = req; ret_addr = ra; ret_req = with_ret; ret_cause = 3'd6;
    #1;
    check({tag, " R2 grant"}, 32'(exc_ack), 32'(exp_ack));
    if (with_ret) check({tag, " R11 return lost"}, 32'(ret_ack), 32'd0);
    expect_pc(exp_pc, {tag, " R6 vector"});
    cyc();
    exc_req = '0; ret_req = 1'b0;
    check({tag, " R4 status"}, psr_cur, exp_psr);
    cyc();
  endtask

  task automatic do_return(input logic [2:0] cz, input logic [31:0] exp_pc,
                           input logic [31:0] exp_psr, input string tag);
    ret_req = 1'b1; ret_cause = cz;
    #1;
    check({tag, " R7 ret_ack"}, 32'(ret_ack), 32'd1);
    expect_pc(exp_pc, {tag, " R5/R7 return pc"});
    cyc();
    ret_req = 1'b0;
    check({tag, " R5/R7 restored status"}, psr_cur, exp_psr);
    cyc();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; exc_req = '0; ret_addr = '0; ret_req = 1'b0; ret_cause = '0;
    tstate_wr = 1'b0; tstate_val = 1'b0; psr_wr = 1'b0; psr_wdata = '0; redir_ready = 1'b0;
    expect_pc(VB, "R1 reset vector");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 reset status", psr_cur, 32'h0000_00D3);
    check("R1 reset redirect valid", 32'(redir_valid), 32'd1);
    redir_ready = 1'b1;
    cyc();

    // R3: both interrupts masked out
    exc_req = 7'b0001100;
    #1 check("R3 masked ack", 32'(exc_ack), 32'd0);
    cyc(); exc_req = '0;
    check("R3 no redirect", 32'(redir_valid), 32'd0);
    check("R3 status kept", psr_cur, 32'h0000_00D3);

    // R10 privileged write
    psr_wr = 1'b1; psr_wdata = 32'hA000_0013; tstate_wr = 1'b1; tstate_val = 1'b1;
    cyc(); psr_wr = 1'b0; tstate_wr = 1'b0;
    check("R10 privileged write", psr_cur, 32'hA000_0013);
    // R9 compact state switch
    tstate_wr = 1'b1; tstate_val = 1'b1;
    cyc(); tstate_wr = 1'b0;
    check("R9 state switch", psr_cur, 32'hA000_0033);

    do_entry(7'b0111000, 32'h0000_1000, 1'b0, 7'b0001000, VB + 32'h18, 32'hA000_0092, "irq");
    do_entry(7'b1111110, 32'h0000_2000, 1'b0, 7'b0000010, VB + 32'h10, 32'hA000_0097, "dabt");
    do_entry(7'b0000100, 32'h0000_3000, 1'b0, 7'b0000100, VB + 32'h1C, 32'hA000_00D1, "fiq");
    do_entry(7'b1000000, 32'h0000_4000, 1'b1, 7'b1000000, VB + 32'h08, 32'hA000_00D3, "swi R11");

    do_return(3'd6, 32'h0000_4000, 32'hA000_00D1, "ret svc");
    do_return(3'd2, 32'h0000_2FFC, 32'hA000_0097, "ret fiq");
    do_return(3'd1, 32'h0000_1FF8, 32'hA000_0092, "ret abt");

    // R8 back-pressure on the redirect stream
    redir_ready = 1'b0;
    exc_req = 7'b0100000; ret_addr = 32'h0000_5000;
    #1 check("R2 undef grant", 32'(exc_ack), 32'h20);
    expect_pc(VB + 32'h04, "R6 undef vector");
    cyc(); exc_req = '0;
    check("R4 undef status", psr_cur, 32'hA000_009B);
    exc_req = 7'b0000001; ret_req = 1'b1; ret_cause = 3'd0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R8 no entry while busy", 32'(exc_ack), 32'd0);
      check("R8 no return while busy", 32'(ret_ack), 32'd0);
      check("R8 pc held", redir_pc, VB + 32'h04);
      cyc();
    end
    exc_req = '0; ret_req = 1'b0; redir_ready = 1'b1;
    cyc();
    check("R8 valid dropped", 32'(redir_valid), 32'd0);
    check("R8 status untouched", psr_cur, 32'hA000_009B);

    do_return(3'd5, 32'h0000_5000, 32'hA000_0092, "ret und");
    do_return(3'd3, 32'h0000_0FFC, 32'hA000_0033, "ret irq");

    // User mode: return ignored, writes limited to flags
    psr_wr = 1'b1; psr_wdata = 32'h0000_0010;
    cyc(); psr_wr = 1'b0;
    check("R10 enter user", psr_cur, 32'h0000_0010);
    ret_req = 1'b1; ret_cause = 3'd3;
    #1 check("R7 user return ignored", 32'(ret_ack), 32'd0);
    cyc(); ret_req = 1'b0;
    check("R7 user no redirect", 32'(redir_valid), 32'd0);
    check("R7 user status kept", psr_cur, 32'h0000_0010);
    psr_wr = 1'b1; psr_wdata = 32'h5000_001F;
    cyc(); psr_wr = 1'b0;
    check("R10 user flags only", psr_cur, 32'h5000_0010);

    do_entry(7'b0010000, 32'h0000_6000, 1'b0, 7'b0010000, VB + 32'h0C, 32'h5000_0097, "pabt");
    do_entry(7'b1111111, 32'h0000_7000, 1'b0, 7'b0000001, VB + 32'h00, 32'h5000_00D3, "reset");
    do_return(3'd0, 32'h0000_7000, 32'h5000_0097, "ret reset");
    do_return(3'd4, 32'h0000_5FFC, 32'h5000_0010, "ret pabt");

    cyc();
    check("R6/R7 all redirects seen", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule